// File: doc/BRIEF.md
# Frame-Aligned Line Control Lead Bank

This block manages six bidirectional control leads toward a line-interface circuit through a small register interface. A direction register sets which leads the block drives. A write-data register supplies the levels for those driven leads. A read-only register reports the level actually seen on every lead. A scratch register holds any byte written to it so that the host path can be tested.

Both directions of lead traffic are aligned to the PCM frame. Write data first goes into a pending register. It reaches the leads only on the next rising edge of the frame-sync input. The lead-state register is loaded at that same edge, once per 125 µs frame, and holds its value until the next edge.

Direction changes take effect on the clock after the write. Each lead is presented as three separate pins: an output enable, an output level, and a sensed pad level. The surrounding pad ring forms the tri-state buffer from these pins.

Top module: `lead_io_bank`

## Requirements
- R1: After reset, the direction register reads 0x0C and `lead_oe_o` is 0x0C. The write-data, lead-state and scratch registers all read 0x00, and `lead_out_o` is 0x00.
- R2: A write to address 0 (direction) updates `lead_oe_o` on the next clock. A 1 bit enables the matching lead as an output. A 0 bit releases it to high impedance.
- R3: `lead_out_o` is the applied data masked by the direction register. A lead whose enable is 0 always has an output level of 0.
- R4: A write to address 1 (write data) is held pending and does not change `lead_out_o`. The pending value reaches the leads on the clock that first sees `fsync_i` high after it was low. Reading address 1 returns the pending value.
- R5: Several writes to address 1 within one frame leave only the last value pending, and only that value is applied at the next frame sync.
- R6: Address 2 (lead state) returns `lead_in_i` as captured at the last frame-sync rising edge. It reports every lead, including leads driven as outputs, and does not follow `lead_in_i` between edges.
- R7: A write to address 2 has no effect on any register or output.
- R8: Address 3 (scratch) stores all 8 written bits and returns them on read.
- R9: Bits 7:6 read as 0 at addresses 0, 1 and 2, whatever was written.
- R10: Addresses 4 to 7 read as 0x00, and writes to them change nothing.
- R11: Holding `fsync_i` high for several clocks causes only one update. Data written while it stays high waits for the next rising edge.
- R12: A write to address 1 in the same clock as a frame-sync rising edge is not applied at that edge. The previously pending value is applied, and the new value waits for the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fsync_i | input | 1 | PCM frame sync, acted on at its rising edge |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| lead_in_i | input | 6 | Sensed pad level of each lead |
| lead_oe_o | output | 6 | Per-lead output enable |
| lead_out_o | output | 6 | Per-lead driven level |

## Verification
The hardest cases to reach are the two frame-edge collisions. In one, a data write lands in the same clock as the sync rising edge. In the other, sync stays high across several clocks while new data is written. Either case hides a wrong edge detector or wrong capture ordering unless the collision is forced on purpose. The bench has a task that raises `fsync_i` and the write strobe together in one cycle. A separate sequence holds sync high across a write. Each then checks that the lead outputs keep the old value until a clean rising edge follows.

// File: rtl/lead_io_pkg.sv
package lead_io_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_DIR   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_DATA  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_STATE = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_TEST  = 3'd3;
endpackage

// File: rtl/lead_io_regs.sv
module lead_io_regs
  import lead_io_pkg::*;
#(
  parameter int N_LEADS = 6,
  parameter logic [DATA_W-1:0] DIR_RST = 8'h0C
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [N_LEADS-1:0]  state_i,
  output logic [N_LEADS-1:0]  dir_o,
  output logic [N_LEADS-1:0]  pend_o,
  output logic [DATA_W-1:0]   rdata_o
);
  logic [N_LEADS-1:0] dir_q, pend_q;
  logic [DATA_W-1:0]  test_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= DIR_RST[N_LEADS-1:0];
      pend_q <= '0;
      test_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        ADDR_DIR:  dir_q  <= wdata_i[N_LEADS-1:0];
        ADDR_DATA: pend_q <= wdata_i[N_LEADS-1:0];
        ADDR_TEST: test_q <= wdata_i;
        default: ;  // state register and unmapped: write dropped
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_DIR:   rdata_o[N_LEADS-1:0] = dir_q;
      ADDR_DATA:  rdata_o[N_LEADS-1:0] = pend_q;
      ADDR_STATE: rdata_o[N_LEADS-1:0] = state_i;
      ADDR_TEST:  rdata_o = test_q;
      default:    rdata_o = '0;
    endcase
  end

  assign dir_o  = dir_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/lead_io_frame.sv
module lead_io_frame #(
  parameter int N_LEADS = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fsync_i,
  input  logic [N_LEADS-1:0] pend_i,
  input  logic [N_LEADS-1:0] dir_i,
  input  logic [N_LEADS-1:0] lead_in_i,
  output logic [N_LEADS-1:0] lead_oe_o,
  output logic [N_LEADS-1:0] lead_out_o,
  output logic [N_LEADS-1:0] state_o
);
  logic               fs_d_q;
  logic               fs_rise;
  logic [N_LEADS-1:0] live_q, state_q;

  assign fs_rise = fsync_i & ~fs_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_d_q  <= 1'b0;
      live_q  <= '0;
      state_q <= '0;
    end else begin
      fs_d_q <= fsync_i;
      if (fs_rise) begin
        live_q  <= pend_i;   // value pending before this edge
        state_q <= lead_in_i;
      end
    end
  end

  for (genvar g = 0; g < N_LEADS; g++) begin : g_lead
    assign lead_oe_o[g]  = dir_i[g];
    assign lead_out_o[g] = dir_i[g] & live_q[g];
  end

  assign state_o = state_q;
endmodule

// File: rtl/lead_io_bank.sv
module lead_io_bank
  import lead_io_pkg::*;
#(
  parameter int N_LEADS = 6,
  parameter logic [DATA_W-1:0] DIR_RST = 8'h0C
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fsync_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [N_LEADS-1:0] lead_in_i,
  output logic [N_LEADS-1:0] lead_oe_o,
  output logic [N_LEADS-1:0] lead_out_o
);
  logic [N_LEADS-1:0] dir, pend, state;

  lead_io_regs #(.N_LEADS(N_LEADS), .DIR_RST(DIR_RST)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .state_i(state), .dir_o(dir), .pend_o(pend), .rdata_o
  );

  lead_io_frame #(.N_LEADS(N_LEADS)) u_frame (
    .clk_i, .rst_ni, .fsync_i,
    .pend_i(pend), .dir_i(dir), .lead_in_i,
    .lead_oe_o, .lead_out_o, .state_o(state)
  );
endmodule

// File: rtl/lead_io_bank_chk.sv
module lead_io_bank_chk
  import lead_io_pkg::*;
#(
  parameter int N_LEADS = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fsync_i,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [N_LEADS-1:0] lead_oe_o,
  input logic [N_LEADS-1:0] lead_out_o
);
  logic fs_d;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) fs_d <= 1'b0;
    else         fs_d <= fsync_i;

  // R3
  always_comb
    if (rst_ni) out_masked_chk: assert ((lead_out_o & ~lead_oe_o) == '0);

  // R2
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_DIR) |=> lead_oe_o == $past(wdata_i[N_LEADS-1:0]));

  // R2
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_DIR) |=> $stable(lead_oe_o));

  // R4
  out_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(fsync_i && !fs_d) && !(wr_en_i && addr_i == ADDR_DIR)) |=> $stable(lead_out_o));

  // R8
  test_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_TEST) |=> (addr_i != ADDR_TEST || rdata_o == $past(wdata_i)));

  // R9
  high_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_DIR || addr_i == ADDR_DATA || addr_i == ADDR_STATE) |-> rdata_o[7:6] == 2'b00);

  // R10
  unmapped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= 3'd4) |-> rdata_o == '0);
endmodule

bind lead_io_bank lead_io_bank_chk #(.N_LEADS(N_LEADS)) u_chk (
  .clk_i, .rst_ni, .fsync_i, .wr_en_i, .addr_i, .wdata_i,
  .rdata_o, .lead_oe_o, .lead_out_o
);

// File: tb/lead_io_bank_tb_top.sv
module lead_io_bank_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 6;
  // {addr[2:0], wdata[7:0], sync, lead_in[5:0], exp_oe[5:0], exp_out[5:0], exp_state[5:0]}
  localparam logic [35:0] VEC [NV] = '{
    {3'd1, 8'h3F, 1'b0, 6'h00, 6'h0C, 6'h00, 6'h00},  // R4 pending only
    {3'd7, 8'hFF, 1'b1, 6'h15, 6'h0C, 6'h0C, 6'h15},  // R3 R6 R10
    {3'd0, 8'hFF, 1'b0, 6'h2A, 6'h3F, 6'h3F, 6'h15},  // R2 R6 hold
    {3'd1, 8'h05, 1'b0, 6'h2A, 6'h3F, 6'h3F, 6'h15},  // R4
    {3'd0, 8'h03, 1'b1, 6'h2A, 6'h03, 6'h01, 6'h2A},  // R2 R3
    {3'd2, 8'hFF, 1'b0, 6'h11, 6'h03, 6'h01, 6'h2A}   // R7
  };

  logic clk = 1'b0, rst_n = 1'b0, fsync = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [5:0] lead_in = '0, lead_oe, lead_out;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lead_io_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .lead_in_i(lead_in), .lead_oe_o(lead_oe), .lead_out_o(lead_out)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, string req, logic [7:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d, logic sync);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; fsync = sync;
    @(negedge clk);
    wr_en = 1'b0; fsync = 1'b0;
  endtask

  task automatic pulse_sync();
    @(negedge clk); fsync = 1'b1;
    @(negedge clk); fsync = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", {2'b0, lead_oe}, 8'h0C);
    chk("R1 out", {2'b0, lead_out}, 8'h00);
    rd(3'd0, "R1 dir", 8'h0C);
    rd(3'd1, "R1 data", 8'h00);
    rd(3'd2, "R1 state", 8'h00);
    rd(3'd3, "R1 test", 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VEC[i];
      lead_in = v[23:18];
      wr(v[35:33], v[32:25], v[24]);
      @(negedge clk);
      chk($sformatf("R2 vec%0d oe", i), {2'b0, lead_oe}, {2'b0, v[17:12]});
      chk($sformatf("R3 vec%0d out", i), {2'b0, lead_out}, {2'b0, v[11:6]});
      rd(3'd2, $sformatf("R6 vec%0d state", i), {2'b0, v[5:0]});
    end
    rd(3'd1, "R7 data untouched", 8'h05);

    // R5 last write wins
    wr(3'd0, 8'h3F, 1'b0);
    wr(3'd1, 8'h11, 1'b0);
    wr(3'd1, 8'h22, 1'b0);
    rd(3'd1, "R5 pending", 8'h22);
    chk("R4 out before sync", {2'b0, lead_out}, 8'h05);
    pulse_sync();
    chk("R5 out after sync", {2'b0, lead_out}, 8'h22);

    // R6 output lead pad level captured, no tracking between edges
    lead_in = 6'h3C;
    pulse_sync();
    lead_in = 6'h01;
    @(negedge clk);
    rd(3'd2, "R6 captured", 8'h3C);

    // R8 scratch
    wr(3'd3, 8'hA5, 1'b0);
    rd(3'd3, "R8 A5", 8'hA5);
    wr(3'd3, 8'h5A, 1'b0);
    rd(3'd3, "R8 5A", 8'h5A);

    // R9 upper bits
    wr(3'd0, 8'hFF, 1'b0);
    rd(3'd0, "R9 dir", 8'h3F);
    wr(3'd1, 8'hC0, 1'b0);
    rd(3'd1, "R9 data", 8'h00);

    // R10 unmapped
    wr(3'd5, 8'hFF, 1'b0);
    rd(3'd5, "R10 read", 8'h00);
    rd(3'd3, "R10 test kept", 8'h5A);
    rd(3'd0, "R10 dir kept", 8'h3F);

    // R11 sync held high
    pulse_sync();
    chk("R11 base", {2'b0, lead_out}, 8'h00);
    @(negedge clk); fsync = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd1; wdata = 8'h2D;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
    chk("R11 no retrigger", {2'b0, lead_out}, 8'h00);
    fsync = 1'b0;
    pulse_sync();
    chk("R11 next edge", {2'b0, lead_out}, 8'h2D);

    // R12 write coincident with sync
    wr(3'd1, 8'h12, 1'b0);
    wr(3'd1, 8'h34, 1'b1);
    @(negedge clk);
    chk("R12 old applied", {2'b0, lead_out}, 8'h12);
    pulse_sync();
    chk("R12 new applied", {2'b0, lead_out}, 8'h34);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule